// File: doc/BRIEF.md
# Token-Passing Sparse Hit Readout

This block reads out a pixel matrix sparsely. While it is idle (acquisition), a hit pulse on any pixel sets that pixel's own hit flag, and the flag stays set until the pixel has been read. A start pulse begins readout. A token then walks the matrix one row at a time and, within a row, from low to high column. It stops only at pixels that need reporting: pixels whose flag is set, and the first column of every row, which is always reported. For each pixel it stops at, the block serialises one fixed-length record on a single output line, one bit per clock. The record holds the column address, the row address and that pixel's time stamp.

The next pixel to visit is found while the current record is still shifting. Records therefore follow one another with no idle bits between them. A read-all level makes every pixel count as hit during readout. When the last row has been finished, a done flag rises and stays up until the next start.

Top module: `sparse_hit_readout`

## Requirements
- R1: A one-cycle pulse on `hit_i[i]` while the block is idle sets the flag of pixel i. The flag is kept through any number of idle cycles, and pixel i is reported in the next readout.
- R2: Hit pulses that arrive while a readout is running have no effect, either on that readout or on the next one.
- R3: Pixels are reported in row-major order: row 0 first, and within a row from the lowest column upward. Pixel index is row*COLS+column. No other pixels are reported, and each reported pixel is reported exactly once.
- R4: The pixel at column 0 of every row is reported in every readout, whether or not it was hit.
- R5: A record is REC_W bits long and is sent most significant bit first. It holds the column address (X_W bits), then the row address (Y_W bits), then the pixel's `ts_i` slice (bits [i*TS_W +: TS_W]), and ends in zero padding. `sdata_o` is 0 whenever `rec_valid_o` is low.
- R6: `rec_valid_o` is high during each record bit. The first bit is on the line in the cycle after the clock edge that accepts `start_i`. Records follow back to back with no gap, one bit per clock.
- R7: Reporting a pixel clears its flag. A following readout with no new hits reports only the column-0 pixels.
- R8: While `read_all_i` is high during readout, every pixel of the matrix is reported, in the order of R3.
- R9: `done_o` is low from reset. It goes low when a start is accepted and rises in the cycle after the last record bit, which is the same cycle in which `rec_valid_o` falls. It then holds until the next accepted start. A start pulse during a readout is ignored.
- R10: After reset, `rec_valid_o`, `sdata_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin readout (accepted only when idle) |
| read_all_i | input | 1 | Treat every pixel as hit during readout |
| hit_i | input | ROWS*COLS | Per-pixel hit pulses, index row*COLS+column |
| ts_i | input | ROWS*COLS*TS_W | Per-pixel time stamps, pixel i at [i*TS_W +: TS_W] |
| sdata_o | output | 1 | Serial record data, MSB first |
| rec_valid_o | output | 1 | High while a record bit is on `sdata_o` |
| done_o | output | 1 | Readout of the whole matrix finished |

## Verification
If a flag is wrong, or the look-ahead search picks the wrong column, the effect shows up at the ports as a missing, extra or reordered record. A wrong record length or a search that stalls shows up as a gap in `rec_valid_o` or a wrong number of bits. Each of these appears within the record boundary that follows, at most REC_W cycles later. A flag that is not cleared stays hidden until the next readout, which is why readouts are repeated without new hits in between. A fault in the field packing corrupts the decoded address or time stamp of the very record it affects.

// File: rtl/sparse_ro_pkg.sv
package sparse_ro_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } ro_state_e;

  // address width of at least one bit
  function automatic int unsigned addr_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/hit_flag_array.sv
module hit_flag_array #(
  parameter int unsigned NPIX  = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [NPIX-1:0]  hit_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [NPIX-1:0]  flag_o
);

  logic [NPIX-1:0] flag_q;

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    logic set_w;
    logic clr_w;
    logic en_w;
    logic d_w;

    always_comb begin
      set_w = arm_i & hit_i[i];
      clr_w = clr_en_i && (clr_idx_i == IDX_W'(i));
      en_w  = set_w | clr_w;
      d_w   = ~clr_w;              // clear wins over set
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (en_w) begin
        flag_q[i] <= d_w;
      end
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/next_hit_finder.sv
module next_hit_finder #(
  parameter int unsigned COLS = 4,
  parameter int unsigned X_W  = 2
) (
  input  logic [COLS-1:0] mask_i,
  input  logic [X_W-1:0]  cur_col_i,
  output logic            found_o,
  output logic [X_W-1:0]  col_o
);

  logic [COLS-1:0] ahead_w;

  for (genvar x = 0; x < COLS; x++) begin : g_ahead
    assign ahead_w[x] = mask_i[x] && (X_W'(x) > cur_col_i);
  end

  // lowest candidate column beyond the current one
  always_comb begin
    found_o = 1'b0;
    col_o   = '0;
    for (int x = COLS - 1; x >= 0; x--) begin
      if (ahead_w[x]) begin
        found_o = 1'b1;
        col_o   = X_W'(x);
      end
    end
  end

endmodule

// File: rtl/record_shifter.sv
module record_shifter #(
  parameter int unsigned REC_W = 30,
  parameter int unsigned FLD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [FLD_W-1:0] field_i,
  input  logic             shift_i,
  output logic             sdata_o
);

  localparam int unsigned PAD_W = REC_W - FLD_W;

  logic [REC_W-1:0] sh_q;
  logic [REC_W-1:0] sh_d;
  logic             sh_en;

  always_comb begin
    sh_en = load_i | shift_i;
    if (load_i) begin
      sh_d = {field_i, {PAD_W{1'b0}}};
    end else begin
      sh_d = {sh_q[REC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign sdata_o = sh_q[REC_W-1];

endmodule

// File: rtl/sparse_hit_readout.sv
module sparse_hit_readout
  import sparse_ro_pkg::*;
#(
  parameter int unsigned COLS  = 4,
  parameter int unsigned ROWS  = 4,
  parameter int unsigned TS_W  = 8,
  parameter int unsigned REC_W = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     read_all_i,
  input  logic [ROWS*COLS-1:0]     hit_i,
  input  logic [ROWS*COLS*TS_W-1:0] ts_i,
  output logic                     sdata_o,
  output logic                     rec_valid_o,
  output logic                     done_o
);

  localparam int unsigned NPIX  = ROWS * COLS;
  localparam int unsigned X_W   = addr_w(COLS);
  localparam int unsigned Y_W   = addr_w(ROWS);
  localparam int unsigned IDX_W = addr_w(NPIX);
  localparam int unsigned FLD_W = X_W + Y_W + TS_W;
  localparam int unsigned CNT_W = addr_w(REC_W);
  localparam logic [Y_W-1:0]   LAST_ROW = Y_W'(ROWS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REC_W - 1);

  ro_state_e        state_q, state_d;
  logic [Y_W-1:0]   row_q, row_d;
  logic [X_W-1:0]   col_q, col_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  logic             load;
  logic [Y_W-1:0]   ld_row;
  logic [X_W-1:0]   ld_col;
  logic [IDX_W-1:0] ld_idx;
  logic [FLD_W-1:0] ld_field;
  logic             shift_en;

  logic [NPIX-1:0]  flag_w;
  logic [COLS-1:0]  row_flags;
  logic [COLS-1:0]  row_mask;
  logic             nxt_found;
  logic [X_W-1:0]   nxt_col;

  hit_flag_array #(
    .NPIX  (NPIX),
    .IDX_W (IDX_W)
  ) flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (state_q == ST_IDLE),
    .hit_i     (hit_i),
    .clr_en_i  (load),
    .clr_idx_i (ld_idx),
    .flag_o    (flag_w)
  );

  // candidates of the row being read: flagged, forced, or column 0
  always_comb begin
    row_flags = flag_w[row_q*COLS +: COLS];
    row_mask  = row_flags | {COLS{read_all_i}} | COLS'(1);
  end

  next_hit_finder #(
    .COLS (COLS),
    .X_W  (X_W)
  ) finder_i (
    .mask_i    (row_mask),
    .cur_col_i (col_q),
    .found_o   (nxt_found),
    .col_o     (nxt_col)
  );

  // next-state logic of the token controller
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    load    = 1'b0;
    ld_row  = row_q;
    ld_col  = col_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load   = 1'b1;
          ld_row = '0;
          ld_col = '0;
          done_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == LAST_BIT) begin
          if (nxt_found) begin
            load   = 1'b1;
            ld_col = nxt_col;
          end else if (row_q != LAST_ROW) begin
            load   = 1'b1;
            ld_row = row_q + Y_W'(1);
            ld_col = '0;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      state_d = ST_SHIFT;
      row_d   = ld_row;
      col_d   = ld_col;
      cnt_d   = '0;
    end
  end

  always_comb begin
    ld_idx   = IDX_W'(ld_row * COLS) + IDX_W'(ld_col);
    ld_field = {ld_col, ld_row, ts_i[ld_idx*TS_W +: TS_W]};
    shift_en = (state_q == ST_SHIFT) && !load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  record_shifter #(
    .REC_W (REC_W),
    .FLD_W (FLD_W)
  ) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .field_i (ld_field),
    .shift_i (shift_en),
    .sdata_o (sdata_o)
  );

  assign rec_valid_o = (state_q == ST_SHIFT);
  assign done_o      = done_q;

endmodule

// File: rtl/sparse_hit_readout_chk.sv
module sparse_hit_readout_chk #(
  parameter int unsigned REC_W = 30
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic sdata_o,
  input logic rec_valid_o,
  input logic done_o
);

  localparam int unsigned CW = (REC_W < 2) ? 1 : $clog2(REC_W);

  logic [CW-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (rec_valid_o) begin
      bit_cnt <= (bit_cnt == CW'(REC_W - 1)) ? '0 : bit_cnt + CW'(1);
    end
  end

  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && rec_valid_o));

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_valid_o) |-> done_o);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R6
  start_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !rec_valid_o) |=> rec_valid_o);

  // R6
  whole_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_valid_o) |-> (bit_cnt == '0));

  // R5
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid_o |-> !sdata_o);

endmodule

bind sparse_hit_readout sparse_hit_readout_chk #(.REC_W(REC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .sdata_o     (sdata_o),
  .rec_valid_o (rec_valid_o),
  .done_o      (done_o)
);

// File: tb/sparse_hit_readout_tb_top.sv
`timescale 1ns/1ps
module sparse_hit_readout_tb_top;

  localparam int COLS  = 4;
  localparam int ROWS  = 4;
  localparam int TS_W  = 8;
  localparam int REC_W = 30;
  localparam int NPIX  = ROWS * COLS;
  localparam int X_W   = $clog2(COLS);
  localparam int Y_W   = $clog2(ROWS);
  localparam int PAD_W = REC_W - X_W - Y_W - TS_W;

  logic                   clk;
  logic                   rst_n;
  logic                   start_i;
  logic                   read_all_i;
  logic [NPIX-1:0]        hit_i;
  logic [NPIX*TS_W-1:0]   ts_i;
  logic                   sdata_o;
  logic                   rec_valid_o;
  logic                   done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  sparse_hit_readout #(
    .COLS (COLS), .ROWS (ROWS), .TS_W (TS_W), .REC_W (REC_W)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .read_all_i  (read_all_i),
    .hit_i       (hit_i),
    .ts_i        (ts_i),
    .sdata_o     (sdata_o),
    .rec_valid_o (rec_valid_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  function automatic logic [TS_W-1:0] ts_of(input int pix, input int seed);
    return TS_W'((pix * 29 + seed * 7 + 3) & ((1 << TS_W) - 1));
  endfunction

  task automatic set_ts(input int seed);
    for (int i = 0; i < NPIX; i++) ts_i[i*TS_W +: TS_W] = ts_of(i, seed);
  endtask

  task automatic pulse_hits(input logic [NPIX-1:0] m);
    @(negedge clk); hit_i = m;
    @(negedge clk); hit_i = '0;
  endtask

  // expected flags: pat; disturb injects hits and a start mid-readout
  task automatic readout(input logic [NPIX-1:0] pat, input bit all, input int seed,
                         input bit disturb, input string req);
    int exp_x[NPIX];
    int exp_y[NPIX];
    int exp_t[NPIX];
    int n_exp = 0;
    int n_rx = 0;
    int nbits = 0;
    int cyc = 0;
    logic [REC_W-1:0] buf_r = '0;
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < COLS; x++)
        if (x == 0 || all || pat[y*COLS + x]) begin
          exp_x[n_exp] = x; exp_y[n_exp] = y;
          exp_t[n_exp] = int'(ts_of(y*COLS + x, seed));
          n_exp++;
        end
    set_ts(seed);
    read_all_i = all;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(rec_valid_o == 1'b1, "R6", "first bit one cycle after start", rec_valid_o, 1);
    check(done_o == 1'b0, "R9", "done low while reading", done_o, 0);
    while (rec_valid_o && cyc < 2000) begin
      buf_r = {buf_r[REC_W-2:0], sdata_o};
      nbits++;
      if (nbits == REC_W) begin
        int rx = int'(buf_r[REC_W-1 -: X_W]);
        int ry = int'(buf_r[REC_W-1-X_W -: Y_W]);
        int rt = int'(buf_r[REC_W-1-X_W-Y_W -: TS_W]);
        int rp = int'(buf_r[PAD_W-1:0]);
        nbits = 0;
        if (n_rx < n_exp) begin
          check(rx == exp_x[n_rx], req, "record column (R3)", rx, exp_x[n_rx]);
          check(ry == exp_y[n_rx], req, "record row (R3)", ry, exp_y[n_rx]);
          check(rt == exp_t[n_rx], "R5", "record time stamp", rt, exp_t[n_rx]);
          check(rp == 0, "R5", "record padding", rp, 0);
        end
        n_rx++;
      end
      cyc++;
      if (disturb && cyc == 40) begin
        hit_i = '1; start_i = 1'b1;      // R2 and R9: both must be ignored
      end else if (disturb && cyc == 41) begin
        hit_i = '0; start_i = 1'b0;
      end
      @(negedge clk);
    end
    check(n_rx == n_exp, req, "record count, no gaps (R6)", n_rx, n_exp);
    check(nbits == 0, "R6", "whole records", nbits, 0);
    check(done_o == 1'b1, "R9", "done after last bit", done_o, 1);
    check(sdata_o == 1'b0, "R5", "line low when idle", sdata_o, 0);
    repeat (3) @(negedge clk);
    check(done_o == 1'b1, "R9", "done held", done_o, 1);
    read_all_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; read_all_i = 1'b0; hit_i = '0; ts_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rec_valid_o == 1'b0, "R10", "rec_valid in reset", rec_valid_o, 0);
    check(sdata_o == 1'b0, "R10", "sdata in reset", sdata_o, 0);
    check(done_o == 1'b0, "R10", "done in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done_o == 1'b0, "R9", "done low after reset", done_o, 0);

    // R4: nothing hit, only column 0 of each row
    readout('0, 1'b0, 1, 1'b0, "R4");

    // R1 R3: every single pixel
    for (int p = 0; p < NPIX; p++) begin
      pulse_hits(NPIX'(1) << p);
      readout(NPIX'(1) << p, 1'b0, p + 2, 1'b0, "R1");
    end

    // R3: sweep of multi-hit patterns
    for (int k = 0; k < 40; k++) begin
      logic [NPIX-1:0] m = NPIX'((k * 4099 + 17 * k * k) & 16'hFFFF);
      pulse_hits(m);
      readout(m, 1'b0, k + 30, 1'b0, "R3");
    end
    pulse_hits('1);
    readout('1, 1'b0, 77, 1'b0, "R3");

    // R1: flags survive a long idle stretch
    pulse_hits(16'h5A3C);
    repeat (60) @(negedge clk);
    readout(16'h5A3C, 1'b0, 90, 1'b0, "R1");

    // R7: flags cleared by the previous readout
    readout('0, 1'b0, 91, 1'b0, "R7");

    // R2: hits and start during readout ignored
    pulse_hits(16'h0F0F);
    readout(16'h0F0F, 1'b0, 92, 1'b1, "R2");
    readout('0, 1'b0, 93, 1'b0, "R2");

    // R8: read-all reports everything, then flags are empty again
    readout('0, 1'b1, 94, 1'b0, "R8");
    pulse_hits(16'h8421);
    readout(16'h8421, 1'b1, 95, 1'b0, "R8");
    readout('0, 1'b0, 96, 1'b0, "R7");

    report();
  end

endmodule